// File: doc/BRIEF.md
# Three-Source Vectored Interrupt Controller

This block arbitrates interrupts for a small 8-bit core. Three sources feed it: a USB event line and overflow pulses from two timers. Each pulse sets a sticky request flag in an 8-bit control byte. The same byte holds a master enable and one enable per source, and firmware reads and writes it as a whole.

The block asks the core for a subroutine call when four conditions hold at once:
- the master enable is set,
- the source's own enable is set,
- the source's flag is set,
- the core reports room on its call stack.

It then drives a one-hot-free take strobe together with the fixed vector of the winning source. At the clock edge where the take strobe is high, the block clears two bits: the served flag and the master enable. This stops nesting in hardware. Firmware may set the master enable again inside the service routine if it wants nesting.

Flags keep collecting while interrupts are blocked, so no request is lost. Any set flag raises a wake-up line for the core's power control. Saving the status register is left to firmware, because the core pushes only the program counter.

Top module: `irq_vic`

## Requirements
- R1: After synchronous reset the control byte reads 0x00, `irq_take` is 0, `irq_vector` is 0x00 and `irq_wake` is 0.
- R2: Control byte layout: bit0 master enable, bit1 USB enable, bit2 timer-0 enable, bit3 timer-1 enable, bit4 USB flag, bit5 timer-0 flag, bit6 timer-1 flag. A write stores bits 6:0, and bit 7 always reads 0.
- R3: A high cycle on `usb_evt`, `tmr0_ovf` or `tmr1_ovf` sets the matching flag from the next clock edge on, whatever the state of the enables.
- R4: `irq_take` is 1 exactly when the master enable is set, `stack_full` is 0, and some source has both its enable and its flag set. A cleared master enable or a cleared source enable keeps the request pending.
- R5: At a clock edge where `irq_take` is 1, the served source's flag and the master enable both clear. The other flags and the source enables keep their values.
- R6: When several sources qualify, USB wins over timer 0, and timer 0 wins over timer 1.
- R7: While `stack_full` is 1, `irq_take` stays 0 and the flag stays set. When `stack_full` returns to 0, the take is made with no further delay.
- R8: If an event pulse and a firmware write that clears the same flag fall in one cycle, the flag ends set.
- R9: `irq_wake` is 1 whenever at least one request flag is set, whatever the enables.
- R10: After a take, a firmware write that sets the master enable again lets another pending enabled source be taken, which allows nesting.
- R11: `irq_vector` is 0x04 for USB, 0x08 for timer 0 and 0x0C for timer 1 while `irq_take` is 1, and 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Firmware write strobe for the control byte |
| reg_wr_data | input | 8 | Byte to write |
| reg_rd_data | output | 8 | Current control byte |
| usb_evt | input | 1 | USB event request |
| tmr0_ovf | input | 1 | Timer 0 overflow request |
| tmr1_ovf | input | 1 | Timer 1 overflow request |
| stack_full | input | 1 | Core call stack has no free entry |
| irq_take | output | 1 | Core shall perform the interrupt call this cycle |
| irq_vector | output | 8 | Call target address of the winning source |
| irq_wake | output | 1 | Wake-up request, any flag pending |

## Verification
Every piece of state in the block is visible in the control byte one edge after it changes. The take strobe and the vector follow that state with no added cycle. So a flag that is not set, or a master enable that is not cleared, shows on `reg_rd_data` right after the offending edge. A wrong priority or vector shows on `irq_vector` in the same cycle as the take. A wrongly latched enable shows as a missing or extra take on the first cycle the qualifying conditions change. The hard cases are the collisions: a pulse landing on a clearing write, a take held off by a full stack, and a request that arrives while the master enable is off and must then be taken once firmware sets the enable again.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NSRC      = 3;
    localparam int REG_W     = 8;
    localparam int VEC_W     = 8;
    localparam int VEC_BASE  = 4;
    localparam int VEC_STEP  = 4;
    localparam int IDX_W     = $clog2(NSRC);

    // Control byte: bit7 unused, 6:4 flags, 3:1 enables, 0 master enable.
    // Index 0 = USB, 1 = timer 0, 2 = timer 1 (also the priority order).
    typedef struct packed {
        logic            unused;
        logic [NSRC-1:0] flag;
        logic [NSRC-1:0] en;
        logic            gie;
    } ctrl_t;

    typedef enum logic [IDX_W-1:0] {
        SRC_USB  = 2'd0,
        SRC_TMR0 = 2'd1,
        SRC_TMR1 = 2'd2
    } src_e;

    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        logic [VEC_W-1:0] v;
        v = VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(idx);
        return v;
    endfunction

    function automatic ctrl_t sanitize(input logic [REG_W-1:0] raw);
        ctrl_t c;
        c        = ctrl_t'(raw);
        c.unused = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
    import irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    input  logic [NSRC-1:0]     hw_set,
    input  logic                ack,
    input  logic [NSRC-1:0]     ack_grant,
    output ctrl_t               q
);

    ctrl_t nxt;

    always_comb begin
        nxt = q;
        if (wr_en)
            nxt = sanitize(wr_data);
        if (ack) begin
            nxt.gie  = 1'b0;
            nxt.flag = nxt.flag & ~ack_grant;
        end
        // hardware set applied last so it always survives
        nxt.flag = nxt.flag | hw_set;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= nxt;
    end

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_set_chk
            AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
                hw_set[i] |=> q.flag[i]); // R3
        end
    endgenerate

    AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (rst)
        (ack && !wr_en) |=> !q.gie); // R5

    AST_ACK_KEEPS_EN: assert property (@(posedge clk) disable iff (rst)
        (ack && !wr_en) |=> $stable(q.en)); // R5

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  ctrl_t               ctrl,
    input  logic                stack_full,
    output logic                take,
    output logic [NSRC-1:0]     grant,
    output logic [VEC_W-1:0]    vector
);

    logic [NSRC-1:0]  ready;
    logic [IDX_W-1:0] win_idx;
    logic             any_ready;

    assign ready = ctrl.flag & ctrl.en;

    always_comb begin
        win_idx   = '0;
        any_ready = 1'b0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (ready[i]) begin
                win_idx   = IDX_W'(i);
                any_ready = 1'b1;
            end
        end
    end

    assign take = any_ready & ctrl.gie & ~stack_full;

    always_comb begin
        grant = '0;
        if (take)
            grant[win_idx] = 1'b1;
    end

    assign vector = take ? vec_of(win_idx) : '0;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R6

    AST_NO_TAKE_FULL: assert property (@(posedge clk) disable iff (rst)
        stack_full |-> !take); // R7

    AST_VEC_IDLE: assert property (@(posedge clk) disable iff (rst)
        !take |-> (vector == '0)); // R11

    AST_USB_FIRST: assert property (@(posedge clk) disable iff (rst)
        (take && ready[SRC_USB]) |-> grant[SRC_USB]); // R6

endmodule

// File: rtl/irq_vic.sv
module irq_vic
    import irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic [7:0]  reg_wr_data,
    output logic [7:0]  reg_rd_data,
    input  logic        usb_evt,
    input  logic        tmr0_ovf,
    input  logic        tmr1_ovf,
    input  logic        stack_full,
    output logic        irq_take,
    output logic [7:0]  irq_vector,
    output logic        irq_wake
);

    ctrl_t           ctrl;
    logic [NSRC-1:0] req;
    logic [NSRC-1:0] grant;

    assign req[SRC_USB]  = usb_evt;
    assign req[SRC_TMR0] = tmr0_ovf;
    assign req[SRC_TMR1] = tmr1_ovf;

    irq_ctrl_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr_en),
        .wr_data   (reg_wr_data),
        .hw_set    (req),
        .ack       (irq_take),
        .ack_grant (grant),
        .q         (ctrl)
    );

    irq_arbiter u_arb (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ctrl),
        .stack_full (stack_full),
        .take       (irq_take),
        .grant      (grant),
        .vector     (irq_vector)
    );

    assign reg_rd_data = ctrl;
    assign irq_wake    = |ctrl.flag;

    AST_TAKE_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        (irq_take && !reg_wr_en) |=> !irq_take); // R5

    AST_WAKE_ON_REQ: assert property (@(posedge clk) disable iff (rst)
        (|req) |=> irq_wake); // R9

    AST_BIT7_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> (reg_rd_data[7] == 1'b0)); // R2

endmodule

// File: tb/irq_vic_tb.sv
module irq_vic_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       reg_wr_en;
    logic [7:0] reg_wr_data;
    logic [7:0] reg_rd_data;
    logic       usb_evt, tmr0_ovf, tmr1_ovf, stack_full;
    logic       irq_take, irq_wake;
    logic [7:0] irq_vector;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_vic u_dut (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .usb_evt(usb_evt), .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
        .stack_full(stack_full), .irq_take(irq_take),
        .irq_vector(irq_vector), .irq_wake(irq_wake)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; reg_wr_en = 1'b0; reg_wr_data = '0;
        usb_evt = 1'b0; tmr0_ovf = 1'b0; tmr1_ovf = 1'b0; stack_full = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
    endtask

    // write a byte, optionally with event pulses in the same cycle
    task automatic step(input bit wr, input logic [7:0] d, input logic [2:0] ev);
        @(negedge clk);
        reg_wr_en = wr; reg_wr_data = d;
        usb_evt = ev[0]; tmr0_ovf = ev[1]; tmr1_ovf = ev[2];
        @(posedge clk); #1;
        reg_wr_en = 1'b0; usb_evt = 1'b0; tmr0_ovf = 1'b0; tmr1_ovf = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "rd", reg_rd_data, 8'h00);
        chk("R1", "take", irq_take, 0);
        chk("R1", "wake", irq_wake, 0);
        chk("R11", "vector idle", irq_vector, 8'h00);
    endtask

    task automatic t_layout();
        do_reset();
        stack_full = 1'b1;
        step(1, 8'hFF, 3'b000);
        chk("R2", "rd after 0xFF", reg_rd_data, 8'h7F);
        chk("R7", "take when full", irq_take, 0);
    endtask

    task automatic t_flag_sets();
        do_reset();
        step(0, 8'h00, 3'b100);
        chk("R3", "t1 flag", reg_rd_data, 8'h40);
        chk("R9", "wake set", irq_wake, 1);
        chk("R4", "no take disabled", irq_take, 0);
        step(1, 8'h00, 3'b000);
        chk("R9", "wake clear", irq_wake, 0);
    endtask

    task automatic t_single(input int idx);
        logic [7:0] en, fl;
        do_reset();
        en = 8'(1 << (idx + 1));
        fl = 8'(1 << (idx + 4));
        step(1, en | 8'h01, 3'b000);
        chk("R4", "no take before req", irq_take, 0);
        step(0, 8'h00, 3'(1 << idx));
        chk("R4", "take", irq_take, 1);
        chk("R11", "vector", irq_vector, 4 * (idx + 1));
        chk("R3", "rd pending", reg_rd_data, en | fl | 8'h01);
        @(posedge clk); #1;
        chk("R5", "rd after take", reg_rd_data, en);
        chk("R5", "take dropped", irq_take, 0);
    endtask

    task automatic t_priority();
        do_reset();
        step(0, 8'h00, 3'b111);
        chk("R3", "all flags", reg_rd_data, 8'h70);
        step(1, 8'h7F, 3'b000);
        chk("R6", "usb first", irq_vector, 8'h04);
        @(posedge clk); #1;
        chk("R5", "usb served", reg_rd_data, 8'h6E);
        step(1, 8'h6F, 3'b000);
        chk("R6", "t0 second", irq_vector, 8'h08);
        @(posedge clk); #1;
        chk("R5", "t0 served", reg_rd_data, 8'h4E);
        step(1, 8'h4F, 3'b000);
        chk("R6", "t1 last", irq_vector, 8'h0C);
        @(posedge clk); #1;
        chk("R5", "t1 served", reg_rd_data, 8'h0E);
    endtask

    task automatic t_stack_full();
        do_reset();
        stack_full = 1'b1;
        step(1, 8'h03, 3'b000);
        step(0, 8'h00, 3'b001);
        repeat (3) @(posedge clk);
        #1;
        chk("R7", "held off", irq_take, 0);
        chk("R7", "still pending", reg_rd_data, 8'h13);
        @(negedge clk);
        stack_full = 1'b0;
        #1;
        chk("R7", "take on release", irq_take, 1);
        chk("R7", "vector on release", irq_vector, 8'h04);
        @(posedge clk); #1;
        chk("R7", "rd after release", reg_rd_data, 8'h02);
    endtask

    task automatic t_gates();
        do_reset();
        step(1, 8'h02, 3'b000);
        step(0, 8'h00, 3'b001);
        chk("R4", "gie off no take", irq_take, 0);
        chk("R4", "gie off flag kept", reg_rd_data, 8'h12);
        step(1, 8'h11, 3'b000);
        chk("R4", "src en off no take", irq_take, 0);
        step(1, 8'h13, 3'b000);
        chk("R4", "both enabled take", irq_take, 1);
    endtask

    task automatic t_collide();
        do_reset();
        step(1, 8'h20, 3'b000);
        step(1, 8'h00, 3'b010);
        chk("R8", "hw set wins", reg_rd_data, 8'h20);
    endtask

    task automatic t_nest();
        do_reset();
        step(1, 8'h07, 3'b000);
        step(0, 8'h00, 3'b010);
        chk("R10", "t0 take", irq_vector, 8'h08);
        @(posedge clk); #1;
        chk("R10", "in service", reg_rd_data, 8'h06);
        step(0, 8'h00, 3'b001);
        chk("R10", "blocked usb", irq_take, 0);
        chk("R10", "blocked usb flag", reg_rd_data, 8'h16);
        step(1, 8'h17, 3'b000);
        chk("R10", "nested take", irq_take, 1);
        chk("R10", "nested vector", irq_vector, 8'h04);
    endtask

    initial begin
        rst = 1'b1; reg_wr_en = 1'b0; reg_wr_data = '0;
        usb_evt = 1'b0; tmr0_ovf = 1'b0; tmr1_ovf = 1'b0; stack_full = 1'b0;
        t_reset();
        t_layout();
        t_flag_sets();
        for (int i = 0; i < 3; i++) t_single(i);
        t_priority();
        t_stack_full();
        t_gates();
        t_collide();
        t_nest();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule